// File: doc/BRIEF.md
# Double-Word Leading-Zero Normalizer

This block normalizes a 32-bit operand that arrives as two 16-bit halves. The high half forms operand bits 31..16 and the low half forms bits 15..0. It counts the zeros above the most significant set bit and shifts the operand left by that count. Zeros enter from the right. The count, the upper half of the shifted word and the lower half are all captured in output registers on the clock edge that accepts the operand.

The input side is a valid/ready stream. Ready is held high permanently, so every cycle with valid high is an accepted operand and there is never back-pressure. The output side needs no ready. The results sit in registers and keep their values until the next accepted operand. A one-cycle valid pulse marks each fresh result.

Top module: `dw_normalizer`

## Requirements
- R1: `in_ready` is 1 in every cycle after reset, so an operand is accepted on every rising edge where `in_valid` is 1.
- R2: `out_cnt` holds the number of leading zeros of the 32-bit operand {`in_hi`, `in_lo`}, where `in_hi` supplies bits 31..16.
- R3: An all-zero operand gives `out_cnt` = 32, and `out_hi` = `out_lo` = 0.
- R4: The stored result equals the operand shifted left by `out_cnt`, with zeros filling from the right. Whenever the operand is nonzero, bit 15 of `out_hi` is 1.
- R5: `out_hi` holds bits 31..16 of the shifted word and `out_lo` holds bits 15..0.
- R6: Results are registered on the same edge that accepts the operand. `out_valid` is 1 for exactly the one cycle that follows each accepting edge.
- R7: While reset is applied, and directly after it, `out_cnt`, `out_hi`, `out_lo` and `out_valid` are all 0.
- R8: On edges where `in_valid` is 0, changes on `in_hi` and `in_lo` have no effect, and all result registers keep their values.
- R9: An operand with bit 31 set gives `out_cnt` = 0 and passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand valid / normalize command |
| in_ready | output | 1 | Always 1: block accepts every cycle |
| in_hi | input | 16 | Operand bits 31..16 |
| in_lo | input | 16 | Operand bits 15..0 |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_cnt | output | 6 | Leading-zero count, 0 to 32 |
| out_hi | output | 16 | Shifted result bits 31..16 |
| out_lo | output | 16 | Shifted result bits 15..0 |

## Verification
Every result is due one edge after its operand. The count, both halves and the valid pulse all change on the rising edge that sees `in_valid` high. The bench drives on the falling edge and samples on the following falling edge, which is half a period after that rising edge. It then drops `in_valid` and samples again one cycle later to confirm that the pulse has ended and the registers are holding. For the hold case, the operand is changed with `in_valid` low and the outputs are read after the next edge has passed.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  // Width of a count able to hold 0..w inclusive.
  function automatic int cnt_width(input int w);
    return $clog2(w) + 1;
  endfunction
endpackage

// File: rtl/nrm_lzc.sv
module nrm_lzc #(
  parameter int W     = 32,
  parameter int CNT_W = nrm_pkg::cnt_width(W)
) (
  input  logic [W-1:0]     din,
  output logic [CNT_W-1:0] zeros
);
  // Scan upward so the highest set bit makes the last assignment.
  always_comb begin
    zeros = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) zeros = CNT_W'(W - 1 - i);
    end
  end

  always_comb begin
    if (din != '0) assert (zeros < CNT_W'(W)) else $error("a_r2_lzc_range");
  end
endmodule

// File: rtl/nrm_shift.sv
module nrm_shift #(
  parameter int W     = 32,
  parameter int CNT_W = nrm_pkg::cnt_width(W)
) (
  input  logic [W-1:0]     din,
  input  logic [CNT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stg [0:CNT_W];

  assign stg[0] = din;
  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP >= W) begin : g_clear
      assign stg[k+1] = amt[k] ? '0 : stg[k];
    end else begin : g_shl
      assign stg[k+1] = amt[k] ? {stg[k][W-1-STEP:0], {STEP{1'b0}}} : stg[k];
    end
  end
  assign dout = stg[CNT_W];

  // A left shift never creates set bits.
  always_comb begin
    assert ($countones(dout) <= $countones(din)) else $error("a_r4_no_new_ones");
  end
endmodule

// File: rtl/dw_normalizer.sv
module dw_normalizer #(
  parameter int HALF_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [HALF_W-1:0]    in_hi,
  input  logic [HALF_W-1:0]    in_lo,
  output logic                 out_valid,
  output logic [nrm_pkg::cnt_width(2*HALF_W)-1:0] out_cnt,
  output logic [HALF_W-1:0]    out_hi,
  output logic [HALF_W-1:0]    out_lo
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int CNT_W  = nrm_pkg::cnt_width(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [WORD_W-1:0] operand, shifted;
  logic [CNT_W-1:0]  zeros;

  assign in_ready = 1'b1;
  assign operand  = {in_hi, in_lo};

  nrm_lzc #(.W(WORD_W), .CNT_W(CNT_W)) u_lzc (
    .din   (operand),
    .zeros (zeros)
  );

  nrm_shift #(.W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .din  (operand),
    .amt  (zeros),
    .dout (shifted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cnt   <= '0;
      out_hi    <= '0;
      out_lo    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cnt <= zeros;
        out_hi  <= shifted[WORD_W-1:HALF_W];
        out_lo  <= shifted[HALF_W-1:0];
      end
    end
  end

  a_r6_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r6_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_cnt) && $stable(out_hi) && $stable(out_lo)));
  a_r4_normalized: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cnt != CNT_MAX) |-> out_hi[HALF_W-1]);
  a_r3_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cnt == CNT_MAX) |-> (out_hi == '0 && out_lo == '0));
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CNT_MAX);
  a_r1_ready: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

// File: tb/dw_normalizer_tb.sv
module dw_normalizer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_hi = '0, in_lo = '0;
  logic        out_valid;
  logic [5:0]  out_cnt;
  logic [15:0] out_hi, out_lo;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dw_normalizer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hi(in_hi), .in_lo(in_lo), .out_valid(out_valid),
    .out_cnt(out_cnt), .out_hi(out_hi), .out_lo(out_lo)
  );

  // {expected count, operand}
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {6'd0,  32'h8000_0000}, {6'd31, 32'h0000_0001}, {6'd16, 32'h0000_8000},
    {6'd15, 32'h0001_0000}, {6'd1,  32'h4000_0000}, {6'd16, 32'h0000_FFFF},
    {6'd3,  32'h1234_5678}, {6'd32, 32'h0000_0000}, {6'd0,  32'hFFFF_FFFF},
    {6'd8,  32'h00F0_0000}, {6'd22, 32'h0000_0300}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] op, input logic [5:0] ecnt, input string req);
    logic [31:0] eres;
    eres = (ecnt == 6'd32) ? 32'h0 : (op << ecnt);
    @(negedge clk);
    in_hi = op[31:16]; in_lo = op[15:0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " cnt"}, 32'(out_cnt), 32'(ecnt));
    check({"R5 hi ", req}, 32'(out_hi), 32'(eres[31:16]));
    check({"R5 lo ", req}, 32'(out_lo), 32'(eres[15:0]));
    check({"R6 valid ", req}, 32'(out_valid), 32'd1);
  endtask

  initial begin
    #1000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R7: reset state
    check("R7 cnt", 32'(out_cnt), 32'd0);
    check("R7 hi", 32'(out_hi), 32'd0);
    check("R7 lo", 32'(out_lo), 32'd0);
    check("R7 valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 valid after release", 32'(out_valid), 32'd0);
    check("R1 ready", 32'(in_ready), 32'd1);

    // R2 / R4 table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][31:0], VEC[i][37:32], "R2 R4 table");
    end

    // R9: bit 31 set passes through
    run_op(32'hA5A5_0F0F, 6'd0, "R9 passthrough");
    // R3: all-zero operand
    run_op(32'h0, 6'd32, "R3 zero");
    // R6: pulse ends one cycle later
    @(negedge clk);
    check("R6 pulse ended", 32'(out_valid), 32'd0);

    // R8: operand changes without valid are ignored
    run_op(32'h0000_0040, 6'd25, "R8 setup");
    in_hi = 16'hFFFF; in_lo = 16'h1234;
    @(negedge clk);
    @(negedge clk);
    check("R8 cnt held", 32'(out_cnt), 32'd25);
    check("R8 hi held", 32'(out_hi), 32'h8000);
    check("R8 lo held", 32'(out_lo), 32'h0000);
    check("R8 valid low", 32'(out_valid), 32'd0);

    // R6: back-to-back operands each give a result
    @(negedge clk);
    in_hi = 16'h0002; in_lo = 16'h0000; in_valid = 1'b1;
    @(negedge clk);
    check("R6 b2b first cnt", 32'(out_cnt), 32'd14);
    in_hi = 16'h0000; in_lo = 16'h0004;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 b2b second cnt", 32'(out_cnt), 32'd29);
    check("R6 b2b valid", 32'(out_valid), 32'd1);
    check("R1 ready still", 32'(in_ready), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule